// File: doc/BRIEF.md
# Per-Output FIFO Request Arbiter

This block is the output controller for one output port of a cell switch whose cells wait in buffers at the inputs. Every input that receives a cell puts a routing request on a broadcast bus: a valid bit, the destination output address, and the location of the cell in that input's buffer. The controller keeps only the requests addressed to its own output and appends them to a destination queue. On each time-slot strobe it removes the request at the head of that queue and returns a grant that names the owning input and the cell location. The input then sends that cell on the output link.

All N inputs may address this output in the same cycle. The whole batch is stored in that cycle, in an order that starts at a pseudo-random input and continues in ascending index order with wrap-around. Requests from an earlier cycle are always granted before requests from a later cycle. The queue is N entries deep. Each input has at most one outstanding request per output, so the queue never holds more than N entries.

Top module: `dest_req_arbiter`

## Requirements
- R1: A request from input i is queued only when `req_valid[i]` is 1 and its destination field (bits `i*ADDR_W +: ADDR_W` of `req_dest`) equals `OWN_ADDR`. A valid request with any other destination is ignored and is never granted.
- R2: Every matching request in a cycle is stored in that same cycle, for any batch size from 1 to N. Each one is later granted exactly once.
- R3: The queue never holds more than N requests.
- R4: Requests queued in an earlier cycle are granted before any request queued in a later cycle.
- R5: Within one batch, the grant order is a rotation of ascending input index. After input a, the next input granted is the next matching input above a, wrapping from N-1 to 0.
- R6: A strobe on `slot_tick` with a non-empty queue raises `gnt_valid` for exactly one cycle, starting on the clock edge after the strobe. In that cycle `gnt_input` holds the head request's input index and `gnt_loc` holds the location field from bits `i*LOC_W +: LOC_W` of `req_loc`.
- R7: No grant is issued in a cycle that follows a clock edge without a strobe. A strobe with an empty queue also issues no grant.
- R8: After synchronous active-low reset, `gnt_valid` is 0 and the queue is empty.
- R9: A request that arrives on the same clock edge as a strobe cannot win that strobe. The strobe pops only requests queued on earlier edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_tick | input | 1 | Time-slot strobe; pops one request |
| req_valid | input | N_IN | One valid bit per input on the request bus |
| req_dest | input | N_IN*ADDR_W | Destination output address of each input's request |
| req_loc | input | N_IN*LOC_W | Cell location of each input's request |
| gnt_valid | output | 1 | Grant issued this cycle |
| gnt_input | output | $clog2(N_IN) | Index of the granted input |
| gnt_loc | output | LOC_W | Cell location carried by the granted request |

## Verification
Two functions can fall on the same clock edge: enqueueing a new batch and popping the head for a slot strobe. The bench provokes this in two ways. It raises the strobe on the same edge as a request that arrives at an empty queue. It also queues a second batch behind a first one before any strobe. A correct result is no grant on the coinciding strobe, followed by a grant of the new request on the next strobe. In the second case, the first batch's inputs must all be granted before any input of the second batch. The bench checks this from the returned input indices and the batch tag that it encodes in each location field.

// File: rtl/arb_pkg.sv
// Package: shared helpers for the destination request arbiter.
// Assumes every ring index is below the modulus passed in.
package arb_pkg;

    // Width of the pseudo-random generator that picks the batch start point.
    localparam int LFSR_W = 8;

    // Modular add used for ring pointers and rotations.
    function automatic int unsigned ring_add(int unsigned a, int unsigned b,
                                             int unsigned n);
        return (a + b) % n;
    endfunction

endpackage

// File: rtl/arb_lfsr.sv
// Module: free-running Galois LFSR. It produces the rotating start point used
// to order a batch of requests that arrive in the same cycle.
// Assumes N >= 2. The start point is the state reduced modulo N.
module arb_lfsr #(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter logic [arb_pkg::LFSR_W-1:0] SEED = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] start_pt
);
    import arb_pkg::*;

    logic [LFSR_W-1:0] state;

    // Purpose: advance the generator every cycle (taps 8,6,5,4).
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= {1'b0, state[LFSR_W-1:1]} ^
                             (state[0] ? 8'hB8 : 8'h00);
    end

    // Purpose: fold the state into a legal input index.
    always_comb start_pt = IDX_W'(int'(state) % N);

    // The state never reaches zero, or the generator would stop.
    p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/arb_addr_filter.sv
// Module: address filter. It marks each bus lane whose valid request targets
// this output's address.
// Assumes the bus is packed lane by lane, lane 0 in the low bits.
module arb_addr_filter #(
    parameter int N      = 4,
    parameter int ADDR_W = 2,
    parameter logic [ADDR_W-1:0] OWN_ADDR = '0
) (
    input  logic [N-1:0]        req_valid,
    input  logic [N*ADDR_W-1:0] req_dest,
    output logic [N-1:0]        match
);
    // Purpose: one comparator per lane.
    for (genvar g = 0; g < N; g++) begin : g_lane
        assign match[g] = req_valid[g] &&
                          (req_dest[g*ADDR_W +: ADDR_W] == OWN_ADDR);
    end
endmodule

// File: rtl/arb_batch_order.sv
// Module: batch ordering. It lists the matched lanes in ascending order with
// wrap-around, beginning at the start point, and counts them.
// Assumes start_pt < N.
module arb_batch_order #(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int CNT_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              match,
    input  logic [IDX_W-1:0]          start_pt,
    output logic [N-1:0][IDX_W-1:0]   ord_idx,
    output logic [CNT_W-1:0]          ord_n
);
    import arb_pkg::*;

    // Purpose: compact the matched lanes in rotated order.
    always_comb begin
        int unsigned pos;
        int unsigned lane;
        pos = 0;
        for (int k = 0; k < N; k++) ord_idx[k] = '0;
        for (int k = 0; k < N; k++) begin
            lane = ring_add(int'(start_pt), k, N);
            if (match[lane]) begin
                ord_idx[pos] = IDX_W'(lane);
                pos = pos + 1;
            end
        end
        ord_n = CNT_W'(pos);
    end

    // The list covers the whole batch, so none of it is dropped.
    p_batch_whole_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ord_n) == $countones(match));
    // The first listed lane is matched whenever the batch is non-empty.
    p_first_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ord_n != '0) |-> match[ord_idx[0]]);
endmodule

// File: rtl/arb_dest_fifo.sv
// Module: destination queue. It is an N-entry ring that accepts up to N
// entries per cycle and releases one entry per pop.
// Assumes the caller never pushes more than the free space.
module arb_dest_fifo #(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int LOC_W = 4,
    parameter int CNT_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        push_n,
    input  logic [N-1:0][IDX_W-1:0] push_idx,
    input  logic [N-1:0][LOC_W-1:0] push_loc,
    input  logic                    pop,
    output logic [IDX_W-1:0]        head_idx,
    output logic [LOC_W-1:0]        head_loc,
    output logic                    empty
);
    import arb_pkg::*;

    logic [N-1:0][IDX_W-1:0] mem_idx;
    logic [N-1:0][LOC_W-1:0] mem_loc;
    logic [IDX_W-1:0]        wr_ptr, rd_ptr;
    logic [CNT_W-1:0]        count;
    logic                    pop_ok;

    assign empty    = (count == '0);
    assign pop_ok   = pop && !empty;
    assign head_idx = mem_idx[rd_ptr];
    assign head_loc = mem_loc[rd_ptr];

    // Purpose: write the whole batch into consecutive ring slots.
    always_ff @(posedge clk) begin
        for (int j = 0; j < N; j++) begin
            if (j < int'(push_n)) begin
                mem_idx[ring_add(int'(wr_ptr), j, N)] <= push_idx[j];
                mem_loc[ring_add(int'(wr_ptr), j, N)] <= push_loc[j];
            end
        end
    end

    // Purpose: move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= IDX_W'(ring_add(int'(wr_ptr), int'(push_n), N));
            if (pop_ok) rd_ptr <= IDX_W'(ring_add(int'(rd_ptr), 1, N));
            count  <= count + push_n - CNT_W'(pop_ok);
        end
    end

    // The occupancy after this edge stays within the N entries.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) + int'(push_n) - int'(pop_ok) <= N);
    // The count changes only through a push or a pop.
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n == '0 && !pop) |=> $stable(count));
endmodule

// File: rtl/dest_req_arbiter.sv
// Module: per-output request arbiter (top). It filters the broadcast request
// bus by address, queues each batch in rotated order, and grants the head
// one cycle after each slot strobe.
// Assumes each input has at most one outstanding request for this output.
module dest_req_arbiter #(
    parameter int N_IN   = 4,
    parameter int ADDR_W = 2,
    parameter int LOC_W  = 4,
    parameter logic [ADDR_W-1:0] OWN_ADDR = 2'd2,
    localparam int IDX_W = $clog2(N_IN),
    localparam int CNT_W = $clog2(N_IN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    slot_tick,
    input  logic [N_IN-1:0]         req_valid,
    input  logic [N_IN*ADDR_W-1:0]  req_dest,
    input  logic [N_IN*LOC_W-1:0]   req_loc,
    output logic                    gnt_valid,
    output logic [IDX_W-1:0]        gnt_input,
    output logic [LOC_W-1:0]        gnt_loc
);
    logic [N_IN-1:0]             match;
    logic [IDX_W-1:0]            start_pt;
    logic [N_IN-1:0][IDX_W-1:0]  ord_idx;
    logic [N_IN-1:0][LOC_W-1:0]  ord_loc;
    logic [CNT_W-1:0]            ord_n;
    logic [IDX_W-1:0]            head_idx;
    logic [LOC_W-1:0]            head_loc;
    logic                        q_empty;

    arb_addr_filter #(.N(N_IN), .ADDR_W(ADDR_W), .OWN_ADDR(OWN_ADDR)) u_filter (
        .req_valid(req_valid), .req_dest(req_dest), .match(match));

    arb_lfsr #(.N(N_IN), .IDX_W(IDX_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .start_pt(start_pt));

    arb_batch_order #(.N(N_IN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_order (
        .clk(clk), .rst_n(rst_n), .match(match), .start_pt(start_pt),
        .ord_idx(ord_idx), .ord_n(ord_n));

    // Purpose: pick each ordered lane's location field off the bus.
    always_comb begin
        for (int k = 0; k < N_IN; k++)
            ord_loc[k] = req_loc[int'(ord_idx[k])*LOC_W +: LOC_W];
    end

    arb_dest_fifo #(.N(N_IN), .IDX_W(IDX_W), .LOC_W(LOC_W), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_n(ord_n), .push_idx(ord_idx),
        .push_loc(ord_loc), .pop(slot_tick), .head_idx(head_idx),
        .head_loc(head_loc), .empty(q_empty));

    // Purpose: register the grant for the head popped by this strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= 1'b0;
            gnt_input <= '0;
            gnt_loc   <= '0;
        end else begin
            gnt_valid <= slot_tick && !q_empty;
            gnt_input <= head_idx;
            gnt_loc   <= head_loc;
        end
    end

    // A grant always follows a strobe by one cycle.
    p_grant_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> $past(slot_tick));
    // A strobe with a waiting request always yields a grant.
    p_tick_serves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && !q_empty) |=> gnt_valid);
    // No strobe, no grant.
    p_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> !gnt_valid);
endmodule

// File: tb/dest_req_arbiter_bench.sv
// Bench: sweeps every match pattern of a 4-input configuration and checks
// filtering, rotation order, batch age order, same-edge timing and reset.
module dest_req_arbiter_bench;
    localparam int N = 4;
    localparam logic [1:0] OWN = 2'd2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_tick = 1'b0;
    logic [3:0] req_valid = '0;
    logic [7:0] req_dest = '0;
    logic [15:0] req_loc = '0;
    logic       gnt_valid;
    logic [1:0] gnt_input;
    logic [3:0] gnt_loc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dest_req_arbiter #(.N_IN(4), .ADDR_W(2), .LOC_W(4), .OWN_ADDR(OWN)) u_dest_req_arbiter (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .req_valid(req_valid),
        .req_dest(req_dest), .req_loc(req_loc), .gnt_valid(gnt_valid),
        .gnt_input(gnt_input), .gnt_loc(gnt_loc));

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of requests: all lanes in vmask valid, lanes in mmask
    // address this output, others address another output; loc = {tag, lane}.
    task automatic send(input logic [3:0] vmask, input logic [3:0] mmask,
                        input int tag, input bit with_tick);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            req_valid[i] = vmask[i] | mmask[i];
            req_dest[i*2 +: 2] = mmask[i] ? OWN : 2'((int'(OWN) + 1 + (i % 3)) % 4);
            req_loc[i*4 +: 4] = {2'(tag), 2'(i)};
        end
        slot_tick = with_tick;
        @(negedge clk);
        req_valid = '0;
        slot_tick = 1'b0;
    endtask

    task automatic tick(output bit v, output int idx, output int loc);
        @(negedge clk);
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
        v = gnt_valid;
        idx = int'(gnt_input);
        loc = int'(gnt_loc);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit v;
        int idx, loc;
        int got[4];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state and an empty-queue strobe.
        chk(gnt_valid == 1'b0, "R8 reset gnt_valid", int'(gnt_valid), 0);
        tick(v, idx, loc);
        chk(v == 1'b0, "R8 empty after reset", int'(v), 0);

        // R1 R2 R5 R6 R7: sweep every match pattern with mismatched lanes valid.
        for (int m = 0; m < 16; m++) begin
            int k;
            logic [3:0] seen;
            k = $countones(4'(m));
            seen = '0;
            send(4'b1111, 4'(m), m, 1'b0);
            @(negedge clk);
            chk(gnt_valid == 1'b0, "R7 no grant without tick", int'(gnt_valid), 0);
            for (int j = 0; j < k; j++) begin
                tick(v, idx, loc);
                got[j] = idx;
                chk(v == 1'b1, "R6 grant valid after tick", int'(v), 1);
                chk(m[idx] == 1'b1, "R1 granted lane matched", idx, m);
                chk(loc == ((m % 4) * 4 + idx), "R6 location field", loc, (m % 4) * 4 + idx);
                seen[idx] = 1'b1;
            end
            chk(seen == 4'(m), "R2 whole batch granted", int'(seen), m);
            for (int j = 0; j + 1 < k; j++) begin
                int nx;
                nx = -1;
                for (int d = N - 1; d >= 1; d--)
                    if (m[(got[j] + d) % N]) nx = (got[j] + d) % N;
                chk(got[j+1] == nx, "R5 rotated ascending order", got[j+1], nx);
            end
            tick(v, idx, loc);
            chk(v == 1'b0, "R7 empty queue no grant", int'(v), 0);
        end

        // R4 R3: two batches filling all N entries, older served first.
        send(4'b0000, 4'b0011, 1, 1'b0);
        send(4'b0000, 4'b1100, 2, 1'b0);
        for (int j = 0; j < 4; j++) begin
            int exp_tag;
            exp_tag = (j < 2) ? 1 : 2;
            tick(v, idx, loc);
            chk(v == 1'b1, "R3 full queue grant", int'(v), 1);
            chk(loc / 4 == exp_tag, "R4 older batch first", loc / 4, exp_tag);
        end
        tick(v, idx, loc);
        chk(v == 1'b0, "R4 drained", int'(v), 0);

        // R9: request on the same edge as a strobe is not served by it.
        send(4'b0000, 4'b0010, 3, 1'b1);
        chk(gnt_valid == 1'b0, "R9 same-edge strobe", int'(gnt_valid), 0);
        tick(v, idx, loc);
        chk(v == 1'b1 && idx == 1, "R9 next strobe grants lane", idx, 1);

        // R8: reset in the middle clears the queue.
        send(4'b0000, 4'b1001, 0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        tick(v, idx, loc);
        chk(v == 1'b0, "R8 reset clears queue", int'(v), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule